// File: doc/BRIEF.md
# Receive Ring Pointer and Packet Count Registers

This block is the host-facing register set for a receive ring buffer. The host reaches it through a byte-wide register bus made of an address, write data, a write strobe and combinational read data. Through it the host moves the 16-bit ring read pointer, reads the 16-bit hardware write pointer, and keeps track of how many received packets are still waiting to be handled.

The read pointer is moved in two steps. The host first writes the low byte, which goes into a holding register that cannot be read back. The host then writes the high byte, which updates both bytes of the live pointer in the same cycle, so the write controller never sees a half-updated pointer. The write controller signals each completed packet with a one-cycle increment pulse and presents a new write pointer together with an update strobe. When the host has finished with a packet, it writes a command bit that lowers the pending-packet count by one. A packet-pending flag follows the count. A receive-error flag records an aborted packet or an increment arriving while the count is already at its maximum. A single interrupt line combines both flags, each gated by its own enable bit.

Top module: `rxring_ptr_regs`

Register addresses, all 8 bits wide: 0 read-pointer low, 1 read-pointer high, 2 write-pointer low, 3 write-pointer high, 4 packet count, 5 command, 6 flags, 7 interrupt enable. In the flags register, bit 0 is packet-pending and bit 1 is receive-error. In the interrupt-enable register, bit 0 enables the pending flag and bit 1 enables the error flag. Bit 0 of the command register is the decrement bit. A write takes effect at the clock edge on which the strobe is sampled. Read data follows the address combinationally from the registered state.

## Requirements
- R1: After reset, every register reads 0x00 and irq is 0.
- R2: A write to address 0 updates only the hidden holding register. The live read pointer keeps its previous value.
- R3: A write to address 1 loads the written byte into the high half of the live pointer and the most recently held low byte into the low half, both at the same clock edge.
- R4: Addresses 0 and 1 return the live pointer bytes in any order. A held low byte that has not been committed is never visible on rdata.
- R5: Addresses 2 and 3 return the low and high bytes of wrp_val as captured at the last edge where wrp_upd was 1. Host writes to addresses 2 and 3 have no effect.
- R6: Writing a byte with bit 0 set to address 5 lowers the packet count (address 4) by one. Address 5 always reads 0x00.
- R7: A decrement while the count is 0 is ignored, and the count stays 0.
- R8: A pkt_inc pulse raises the count and sets the pending flag (flags bit 0). After a decrement the flag clears if the count has reached 0, and otherwise stays set.
- R9: The count saturates at 255. A pkt_inc at 255 leaves the count at 255 and sets the error flag (flags bit 1).
- R10: A pkt_inc and a decrement in the same cycle leave the count unchanged.
- R11: irq is 1 exactly when (pending AND enable bit 0) OR (error AND enable bit 1).
- R12: A rx_abort pulse sets the error flag. The flag clears only when the host writes 1 to flags bit 1. Writing 0 to that bit leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr |
| pkt_inc | input | 1 | One packet completed (from write controller) |
| rx_abort | input | 1 | Packet aborted (from write controller) |
| wrp_upd | input | 1 | Capture wrp_val |
| wrp_val | input | 16 | New hardware write pointer |
| rdptr | output | 16 | Live read pointer, to write controller |
| irq | output | 1 | Interrupt request |

## Verification
The pointer path is tried with a single low-then-high pair, with repeated low writes before a commit, and with reads in both byte orders interleaved with uncommitted low writes. Together these distinguish a live pointer that leaks the holding register from one that commits late or keeps a stale low byte. The counter is driven with increments alone, decrements down to and past zero, simultaneous increment and decrement, and a long increment run into saturation. These separate floor clamping, ceiling clamping and flag tracking. Flag and enable combinations on irq, along with writes of 0 and 1 to the error bit, show whether clearing depends on the written value.

// File: rtl/rxr_pkg.sv
// Package: shared widths and register addresses for the receive ring
// pointer register block. Assumes a byte-wide bus with 8 addresses.
package rxr_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RDP_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_RDP_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_WRP_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_WRP_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT    = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMD    = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLG    = 3'd6;
    localparam logic [ADDR_W-1:0] A_IEN    = 3'd7;

    localparam int FLG_PEND = 0;
    localparam int FLG_ERR  = 1;
    localparam int CMD_DEC  = 0;
endpackage

// File: rtl/rxr_rdptr.sv
// Module: rxr_rdptr
// Holds the live ring read pointer and a hidden low-byte holding register.
// A low-byte write only fills the holding register; a high-byte write
// commits the high byte and the held low byte together.
// Assumes at most one write strobe per cycle.
module rxr_rdptr #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wdata,
    output logic [2*BW-1:0] live,
    output logic [BW-1:0] held
);
    logic [BW-1:0]   held_q;
    logic [2*BW-1:0] live_q;

    // Capture the low byte into the holding register only
    always_ff @(posedge clk) begin
        if (!rst_n)     held_q <= '0;
        else if (wr_lo) held_q <= wdata;
    end

    // Commit both bytes of the live pointer on a high-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)     live_q <= '0;
        else if (wr_hi) live_q <= {wdata, held_q};
    end

    assign live = live_q;
    assign held = held_q;
endmodule

// File: rtl/rxr_wrptr.sv
// Module: rxr_wrptr
// Keeps the host-visible copy of the hardware write pointer.
// Assumes wrp_upd is driven by the write controller only.
module rxr_wrptr #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [PW-1:0] val,
    output logic [PW-1:0] ptr
);
    // Latch a new write pointer when the controller updates it
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (upd) ptr <= val;
    end
endmodule

// File: rtl/rxr_pktcnt.sv
// Module: rxr_pktcnt
// Pending-packet counter clamped at 0 and at its maximum, plus the
// pending and error flags. Increment and decrement together cancel.
// An increment at the maximum sets the error flag. A set of the error
// flag wins over a host clear in the same cycle.
module rxr_pktcnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic          abort,
    input  logic          err_clr,
    output logic [CW-1:0] cnt,
    output logic          pend,
    output logic          err
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic at_max, at_zero, do_inc, do_dec, err_set;

    // Decide which counter step is allowed this cycle
    always_comb begin
        at_max  = (cnt == CNT_MAX);
        at_zero = (cnt == '0);
        do_inc  = inc && !dec && !at_max;
        do_dec  = dec && !inc && !at_zero;
        err_set = abort || (inc && !dec && at_max);
    end

    // Count pending packets
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (do_inc) cnt <= cnt + 1'b1;
        else if (do_dec) cnt <= cnt - 1'b1;
    end

    // Pending flag: set by a new packet, cleared when a decrement empties the count
    always_ff @(posedge clk) begin
        if (!rst_n)                              pend <= 1'b0;
        else if (do_inc)                         pend <= 1'b1;
        else if (do_dec && cnt == {{(CW-1){1'b0}}, 1'b1}) pend <= 1'b0;
    end

    // Error flag: sticky until the host clears it
    always_ff @(posedge clk) begin
        if (!rst_n)       err <= 1'b0;
        else if (err_set) err <= 1'b1;
        else if (err_clr) err <= 1'b0;
    end
endmodule

// File: rtl/rxring_ptr_regs.sv
// Module: rxring_ptr_regs
// Byte register interface for the receive ring: read pointer with a
// hidden low-byte stage, write pointer view, packet counter with a
// self-clearing decrement command, flags and interrupt enables.
// Assumes a single-cycle write strobe and combinational reads.
module rxring_ptr_regs
    import rxr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              pkt_inc,
    input  logic              rx_abort,
    input  logic              wrp_upd,
    input  logic [PTR_W-1:0]  wrp_val,
    output logic [PTR_W-1:0]  rdptr,
    output logic              irq
);
    logic              wr_lo, wr_hi, dec_cmd, err_clr, wr_ien;
    logic [BYTE_W-1:0] rdp_held;
    logic [PTR_W-1:0]  wrp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pend_q, err_q;
    logic [1:0]        ien_q;

    // Decode host writes into per-register strobes
    always_comb begin
        wr_lo   = bus_we && (bus_addr == A_RDP_LO);
        wr_hi   = bus_we && (bus_addr == A_RDP_HI);
        dec_cmd = bus_we && (bus_addr == A_CMD) && bus_wdata[CMD_DEC];
        err_clr = bus_we && (bus_addr == A_FLG) && bus_wdata[FLG_ERR];
        wr_ien  = bus_we && (bus_addr == A_IEN);
    end

    rxr_rdptr #(.BW(BYTE_W)) u_rdptr (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(bus_wdata), .live(rdptr), .held(rdp_held)
    );

    rxr_wrptr #(.PW(PTR_W)) u_wrptr (
        .clk(clk), .rst_n(rst_n), .upd(wrp_upd), .val(wrp_val), .ptr(wrp_q)
    );

    rxr_pktcnt #(.CW(CNT_W)) u_pktcnt (
        .clk(clk), .rst_n(rst_n), .inc(pkt_inc), .dec(dec_cmd),
        .abort(rx_abort), .err_clr(err_clr),
        .cnt(cnt_q), .pend(pend_q), .err(err_q)
    );

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= bus_wdata[1:0];
    end

    // Read multiplexer; the holding register and the command bit never appear
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RDP_LO: bus_rdata = rdptr[BYTE_W-1:0];
            A_RDP_HI: bus_rdata = rdptr[PTR_W-1:BYTE_W];
            A_WRP_LO: bus_rdata = wrp_q[BYTE_W-1:0];
            A_WRP_HI: bus_rdata = wrp_q[PTR_W-1:BYTE_W];
            A_CNT:    bus_rdata = BYTE_W'(cnt_q);
            A_FLG:    bus_rdata = {{(BYTE_W-2){1'b0}}, err_q, pend_q};
            A_IEN:    bus_rdata = {{(BYTE_W-2){1'b0}}, ien_q};
            default:  bus_rdata = '0;
        endcase
    end

    // Combine gated flags into one interrupt line
    assign irq = (pend_q && ien_q[0]) || (err_q && ien_q[1]);

    logic unused_held;
    assign unused_held = ^rdp_held;
endmodule

// File: rtl/rxring_ptr_regs_chk.sv
// Module: rxring_ptr_regs_chk
// Property checker bound to rxring_ptr_regs; observes bus, counter,
// flags and the read-pointer stage.
module rxring_ptr_regs_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             bus_we,
    input logic [7:0]       bus_rdata,
    input logic             pkt_inc,
    input logic [15:0]      rdptr,
    input logic [7:0]       held,
    input logic [CNT_W-1:0] cnt,
    input logic             pend,
    input logic             dec
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd0) |=> $stable(rdptr)); // R2
    AST_HI_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd1) |=> (rdptr == {$past(bus_wdata), $past(held)})); // R3
    AST_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd5) |-> (bus_rdata == 8'h00)); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && dec && !pkt_inc) |=> (cnt == '0)); // R7
    AST_PEND_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        pend == (cnt != '0)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CMAX && pkt_inc && !dec) |=> (cnt == CMAX)); // R9
    AST_INC_DEC_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_inc && dec) |=> $stable(cnt)); // R10
endmodule

bind rxring_ptr_regs rxring_ptr_regs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pkt_inc(pkt_inc),
    .rdptr(rdptr), .held(rdp_held), .cnt(cnt_q), .pend(pend_q), .dec(dec_cmd)
);

// File: tb/rxring_ptr_regs_tb.sv
`timescale 1ns/100ps
module rxring_ptr_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        pkt_inc = 1'b0;
    logic        rx_abort = 1'b0;
    logic        wrp_upd = 1'b0;
    logic [15:0] wrp_val = '0;
    logic [15:0] rdptr;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxring_ptr_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pkt_inc(pkt_inc),
        .rx_abort(rx_abort), .wrp_upd(wrp_upd), .wrp_val(wrp_val),
        .rdptr(rdptr), .irq(irq)
    );

    // Vector: {we, addr, wdata, inc, read addr, expected, requirement number}
    localparam int NV = 18;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 3'd0, 8'h34, 1'b0, 3'd0, 8'h00, 4'd2},  // R2 low write hidden
        {1'b1, 3'd1, 8'h12, 1'b0, 3'd0, 8'h34, 4'd3},  // R3 commit low
        {1'b0, 3'd0, 8'h00, 1'b0, 3'd1, 8'h12, 4'd4},  // R4 read high
        {1'b1, 3'd0, 8'hAA, 1'b0, 3'd1, 8'h12, 4'd2},  // R2 high unchanged
        {1'b1, 3'd0, 8'hBB, 1'b0, 3'd0, 8'h34, 4'd4},  // R4 held byte not visible
        {1'b1, 3'd1, 8'h56, 1'b0, 3'd0, 8'hBB, 4'd3},  // R3 last low wins
        {1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 8'h01, 4'd8},  // R8 increment
        {1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 8'h02, 4'd8},
        {1'b0, 3'd0, 8'h00, 1'b0, 3'd6, 8'h01, 4'd8},  // R8 pending set
        {1'b1, 3'd5, 8'h01, 1'b0, 3'd4, 8'h01, 4'd6},  // R6 decrement
        {1'b0, 3'd0, 8'h00, 1'b0, 3'd5, 8'h00, 4'd6},  // R6 command reads 0
        {1'b0, 3'd0, 8'h00, 1'b0, 3'd6, 8'h01, 4'd8},  // R8 stays set
        {1'b1, 3'd5, 8'h01, 1'b0, 3'd4, 8'h00, 4'd6},
        {1'b0, 3'd0, 8'h00, 1'b0, 3'd6, 8'h00, 4'd8},  // R8 cleared at zero
        {1'b1, 3'd5, 8'h01, 1'b0, 3'd4, 8'h00, 4'd7},  // R7 floor
        {1'b1, 3'd2, 8'hFF, 1'b0, 3'd2, 8'h00, 4'd5},  // R5 write ignored
        {1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 8'h01, 4'd8},
        {1'b1, 3'd5, 8'h01, 1'b1, 3'd4, 8'h01, 4'd10}  // R10 cancel
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic read_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, req);
    endtask

    // One clocked step: drive at negedge, pass a posedge, release at negedge
    task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d, input logic inc);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; pkt_inc = inc;
        @(negedge clk);
        bus_we = 1'b0; pkt_inc = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of every register and irq
        for (int a = 0; a < 8; a++) read_chk(3'(a), 8'h00, "R1");
        check({7'd0, irq}, 8'h00, "R1");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][27], VEC[i][26:24], VEC[i][23:16], VEC[i][15]);
            read_chk(VEC[i][14:12], VEC[i][11:4], $sformatf("R%0d", VEC[i][3:0]));
        end

        // R5 write pointer capture
        @(negedge clk); wrp_upd = 1'b1; wrp_val = 16'hBEEF;
        @(negedge clk); wrp_upd = 1'b0; wrp_val = 16'h0000;
        read_chk(3'd2, 8'hEF, "R5");
        read_chk(3'd3, 8'hBE, "R5");
        step(1'b1, 3'd3, 8'h11, 1'b0);
        read_chk(3'd3, 8'hBE, "R5");

        // R9 saturation: count is 1, push far past the ceiling
        for (int k = 0; k < 260; k++) step(1'b0, 3'd0, 8'h00, 1'b1);
        read_chk(3'd4, 8'hFF, "R9");
        read_chk(3'd6, 8'h03, "R9");

        // R11 irq gating
        check({7'd0, irq}, 8'h00, "R11");
        step(1'b1, 3'd7, 8'h02, 1'b0);
        check({7'd0, irq}, 8'h01, "R11");

        // R12 writing 0 keeps error, writing 1 clears it
        step(1'b1, 3'd6, 8'h00, 1'b0);
        read_chk(3'd6, 8'h03, "R12");
        step(1'b1, 3'd6, 8'h02, 1'b0);
        read_chk(3'd6, 8'h01, "R12");
        check({7'd0, irq}, 8'h00, "R11");
        step(1'b1, 3'd7, 8'h01, 1'b0);
        check({7'd0, irq}, 8'h01, "R11");

        // R12 abort sets error
        step(1'b1, 3'd7, 8'h02, 1'b0);
        check({7'd0, irq}, 8'h00, "R11");
        @(negedge clk); rx_abort = 1'b1;
        @(negedge clk); rx_abort = 1'b0;
        read_chk(3'd6, 8'h03, "R12");
        check({7'd0, irq}, 8'h01, "R11");

        // R1 reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_chk(3'd4, 8'h00, "R1");
        read_chk(3'd1, 8'h00, "R1");
        read_chk(3'd6, 8'h00, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule